// File: doc/BRIEF.md
# Command and Status Register with Cooperative Peripheral Lock

This block holds the one-byte command register of a bus-attached input/output node and assembles the one-byte status value returned when a master reads it. The command byte picks how the line supervisor chooses its receive line, switches line surveillance on or off, and carries a cooperative ownership lock. The lock is a busy flag plus a module number that several bus masters use to share one peripheral. A master reads the status first and claims the peripheral only if it is free. The lock never blocks port writes. It is a flag and nothing more.

Command bytes arrive on a valid/ready interface. `cmd_ready` is held high, so every beat with `cmd_valid` high is taken on that clock edge and no write is ever back-pressured. Line supervisor results come in on plain pins: the selected line index, the triple-sample agreement flag and the safety state. The mode fields go out on plain pins too. `mode_reload` tells the supervisor to restart its line selection from the new code.

Field layout, least significant first: [1:0] start line, [2] forced mode, [3] surveillance inhibit, [6:4] owner module number, [7] busy. A line-mode code of `011` is the transparent code. It rewrites bits 7..3 and leaves the line selection alone.

Top module: `csr_lock_regs`

## Requirements
- R1: After reset `mode_code` is 000 (automatic mode starting on line 0), `surveil_off` is 0, `lock_busy` is 0, `lock_owner` is 0 and `mode_reload` is 0.
- R2: `cmd_ready` is always 1. A beat with `cmd_valid` high is taken at that clock edge. While `cmd_valid` is low, every command field keeps its value.
- R3: An accepted byte whose bits [2:0] are not 011 sets `mode_code` to those bits. `mode_reload` is then 1 for exactly the cycle after the accepting edge.
- R4: An accepted byte whose bits [2:0] are 011 leaves `mode_code` unchanged and does not raise `mode_reload`. Bits 7..3 are still updated.
- R5: `surveil_off` equals bit 3 of the last accepted byte (1 means surveillance is inhibited).
- R6: `lock_busy` equals bit 7 and `lock_owner` equals bits [6:4] of the last accepted byte. Status bits [7:4] read back {`lock_busy`, `lock_owner`}.
- R7: Status bits [2:0] read {`sup_tsc`, `sup_line`}. 0xx gives the line index with triple sampling incorrect; 1xx gives the line index with triple sampling correct.
- R8: Status bit 3 equals `sup_safety` (0 in normal mode, 1 in safety mode), with no added latency.
- R9: Writes are accepted exactly the same way while `sup_safety` is 1.
- R10: `mode_code` never holds 011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte valid |
| cmd_ready | output | 1 | Always 1: the register takes every beat |
| cmd_data | input | 8 | Command byte |
| sup_line | input | 2 | Line currently selected by the supervisor |
| sup_tsc | input | 1 | All three receive lines agree |
| sup_safety | input | 1 | Supervisor is in safety mode |
| mode_code | output | 3 | Stored line-mode code |
| mode_reload | output | 1 | One-cycle pulse: supervisor restarts from `mode_code` |
| surveil_off | output | 1 | Line surveillance inhibited |
| lock_busy | output | 1 | Peripheral marked busy |
| lock_owner | output | 3 | Module number of the owner |
| status_byte | output | 8 | Assembled status value |

## Verification
The bench concentrates on the transparent code 011. A design that decoded it like any other code would overwrite the line selection, show 011 on `mode_code`, or fire a spurious `mode_reload` that makes the supervisor jump lines. Back-to-back writes check that the reload pulse lasts exactly one cycle and does not stretch or drop. Writes made while safety mode is active check that nothing gates the register on safety state. Idle cycles with a busy lock held check that the lock fields do not decay and that the status byte follows the supervisor pins in the same cycle.

// File: rtl/csr_lock_pkg.sv
package csr_lock_pkg;
  // Width of the line-mode code: line index plus the forced-mode bit.
  function automatic int code_width(input int line_w);
    return line_w + 1;
  endfunction

  // Total command/status width: code, surveillance bit, owner, busy.
  function automatic int cmd_width(input int line_w, input int owner_w);
    return line_w + 1 + 1 + owner_w + 1;
  endfunction
endpackage

// File: rtl/csr_cmd_reg.sv
module csr_cmd_reg
  import csr_lock_pkg::*;
#(
  parameter int LINE_W  = 2,
  parameter int OWNER_W = 3
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   wr_en,
  input  logic [cmd_width(LINE_W, OWNER_W)-1:0]  wr_data,
  output logic [code_width(LINE_W)-1:0]          code_q,
  output logic                                   reload_q,
  output logic                                   surv_q,
  output logic                                   busy_q,
  output logic [OWNER_W-1:0]                     owner_q
);
  localparam int CW      = code_width(LINE_W);
  localparam int SURV_B  = CW;
  localparam int OWN_LO  = CW + 1;
  localparam int BUSY_B  = CW + 1 + OWNER_W;
  // Transparent code: forced bit clear, all line bits set.
  localparam logic [CW-1:0] TRANSP = {1'b0, {LINE_W{1'b1}}};

  logic          is_transp;
  logic [CW-1:0] code_in;

  assign code_in   = wr_data[CW-1:0];
  assign is_transp = (code_in == TRANSP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q   <= '0;
      reload_q <= 1'b0;
      surv_q   <= 1'b0;
      busy_q   <= 1'b0;
      owner_q  <= '0;
    end else begin
      reload_q <= wr_en && !is_transp;
      if (wr_en) begin
        surv_q  <= wr_data[SURV_B];
        busy_q  <= wr_data[BUSY_B];
        owner_q <= wr_data[OWN_LO +: OWNER_W];
        if (!is_transp) code_q <= code_in;
      end
    end
  end

  // R10: the transparent code is never stored
  p_no_transp_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    code_q != TRANSP);

  // R3: a reload pulse follows only a non-transparent accepted write
  p_reload_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !is_transp |=> reload_q && code_q == $past(code_in));

  // R4: a transparent write keeps the code and raises no reload
  p_transp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && is_transp |=> !reload_q && $stable(code_q));

  // R2: without a write every field holds
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !reload_q && $stable(code_q) && $stable(surv_q)
               && $stable(busy_q) && $stable(owner_q));
endmodule

// File: rtl/csr_status_pack.sv
module csr_status_pack
  import csr_lock_pkg::*;
#(
  parameter int LINE_W  = 2,
  parameter int OWNER_W = 3
) (
  input  logic [LINE_W-1:0]                      line_idx,
  input  logic                                   tsc_ok,
  input  logic                                   safety,
  input  logic                                   busy,
  input  logic [OWNER_W-1:0]                     owner,
  output logic [cmd_width(LINE_W, OWNER_W)-1:0]  status
);
  // Layout mirrors the command byte: code, mode bit, owner, busy.
  assign status = {busy, owner, safety, tsc_ok, line_idx};

  // R7 / R8: status fields track their sources
  always_comb begin
    a_status_src_r8: assert (status[LINE_W+1] == safety);
  end
endmodule

// File: rtl/csr_lock_regs.sv
module csr_lock_regs
  import csr_lock_pkg::*;
#(
  parameter int LINE_W  = 2,
  parameter int OWNER_W = 3
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cmd_valid,
  output logic                                   cmd_ready,
  input  logic [cmd_width(LINE_W, OWNER_W)-1:0]  cmd_data,
  input  logic [LINE_W-1:0]                      sup_line,
  input  logic                                   sup_tsc,
  input  logic                                   sup_safety,
  output logic [code_width(LINE_W)-1:0]          mode_code,
  output logic                                   mode_reload,
  output logic                                   surveil_off,
  output logic                                   lock_busy,
  output logic [OWNER_W-1:0]                     lock_owner,
  output logic [cmd_width(LINE_W, OWNER_W)-1:0]  status_byte
);
  logic take;

  // The register sinks every beat; no state gates acceptance.
  assign cmd_ready = 1'b1;
  assign take      = cmd_valid && cmd_ready;

  csr_cmd_reg #(.LINE_W(LINE_W), .OWNER_W(OWNER_W)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (take),
    .wr_data  (cmd_data),
    .code_q   (mode_code),
    .reload_q (mode_reload),
    .surv_q   (surveil_off),
    .busy_q   (lock_busy),
    .owner_q  (lock_owner)
  );

  csr_status_pack #(.LINE_W(LINE_W), .OWNER_W(OWNER_W)) u_stat (
    .line_idx (sup_line),
    .tsc_ok   (sup_tsc),
    .safety   (sup_safety),
    .busy     (lock_busy),
    .owner    (lock_owner),
    .status   (status_byte)
  );

  // R9: a write in safety mode is taken like any other
  p_safety_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && sup_safety |=> lock_busy == $past(cmd_data[cmd_width(LINE_W, OWNER_W)-1]));

  // R6: busy/owner read back in the status byte
  p_lock_readback_r6: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[cmd_width(LINE_W, OWNER_W)-1] == lock_busy);
endmodule

// File: tb/csr_lock_regs_bench.sv
module csr_lock_regs_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [7:0] cmd_data = 8'h00;
  logic [1:0] sup_line = 2'd0;
  logic       sup_tsc = 1'b0;
  logic       sup_safety = 1'b0;
  logic [2:0] mode_code;
  logic       mode_reload;
  logic       surveil_off;
  logic       lock_busy;
  logic [2:0] lock_owner;
  logic [7:0] status_byte;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  // Behavioural reference state
  logic [7:0] m_cmd;
  logic [2:0] m_code;
  logic       m_reload;

  always #5 clk = ~clk;

  csr_lock_regs u_csr_lock_regs (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .sup_line(sup_line), .sup_tsc(sup_tsc),
    .sup_safety(sup_safety), .mode_code(mode_code), .mode_reload(mode_reload),
    .surveil_off(surveil_off), .lock_busy(lock_busy), .lock_owner(lock_owner),
    .status_byte(status_byte)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model: update at each rising edge from stable inputs
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_cmd = 8'h00; m_code = 3'b000; m_reload = 1'b0;
    end else begin
      m_reload = cmd_valid && (cmd_data[2:0] != 3'b011);
      if (cmd_valid) begin
        m_cmd[7:3] = cmd_data[7:3];
        if (cmd_data[2:0] != 3'b011) m_code = cmd_data[2:0];
      end
    end
  end

  // Compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 ready",        int'(cmd_ready), 1);
      check("R3/R4 mode_code", int'(mode_code), int'(m_code));
      check("R3 reload",       int'(mode_reload), int'(m_reload));
      check("R5 surveil",      int'(surveil_off), int'(m_cmd[3]));
      check("R6 busy",         int'(lock_busy), int'(m_cmd[7]));
      check("R6 owner",        int'(lock_owner), int'(m_cmd[6:4]));
      check("R6 status hi",    int'(status_byte[7:4]), int'(m_cmd[7:4]));
      check("R7 status lo",    int'(status_byte[2:0]), int'({sup_tsc, sup_line}));
      check("R8 status b3",    int'(status_byte[3]), int'(sup_safety));
      check("R10 no 011",      int'(mode_code == 3'b011), 0);
    end
  end

  task automatic wr(input logic [7:0] b);
    cmd_valid = 1'b1; cmd_data = b;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_data = 8'hA5;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Watchdog
  always @(posedge clk) begin
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 mode_code", int'(mode_code), 0);
    check("R1 reload",    int'(mode_reload), 0);
    check("R1 fields",    int'({surveil_off, lock_busy, lock_owner}), 0);
    @(negedge clk);
    // R3 normal writes, back to back
    wr(8'h05); wr(8'h06); wr(8'h04);
    idle(2);
    // R4 transparent: claim lock, inhibit surveillance, keep line
    wr(8'hDB);   // 1101_1011: busy, owner 5, surveil off, code 011
    check("R4 code kept", int'(mode_code), 4);
    check("R4 no reload", int'(mode_reload), 0);
    idle(3);     // R6 lock holds while idle
    check("R6 lock held", int'({lock_busy, lock_owner}), 4'hD);
    // R7/R8 supervisor pins
    sup_line = 2'd2; sup_tsc = 1'b1; idle(1);
    sup_line = 2'd1; sup_tsc = 1'b0; sup_safety = 1'b1; idle(1);
    // R9 writes in safety mode
    wr(8'h07);
    check("R9 safety write", int'(mode_code), 7);
    wr(8'h03);   // transparent in safety, releases lock
    check("R9 lock freed", int'(lock_busy), 0);
    sup_safety = 1'b0;
    // R10 transparent immediately after reset-style code
    wr(8'h00); wr(8'h0B); wr(8'h01);
    // Pseudo-random traffic
    for (int i = 0; i < 300; i++) begin
      cmd_valid = ($urandom % 3) != 0;
      cmd_data  = 8'($urandom);
      sup_line  = 2'($urandom % 3);
      sup_tsc   = 1'($urandom);
      sup_safety = 1'($urandom);
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    idle(2);
    // R1 again after mid-run reset
    rst_n = 1'b0; idle(2); rst_n = 1'b1;
    check("R1 re-reset", int'({lock_busy, lock_owner, surveil_off, mode_code}), 0);
    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule